// File: doc/BRIEF.md
# Trimmed Real-Time Seconds Counter

This block keeps wall-clock time as a 32-bit count of seconds. A 32.768 kHz tick enable, synchronous to the system clock, drives a prescaler. The prescaler's overflow advances the seconds register by one. A slow or fast crystal can be corrected with a signed trim code, which shortens or lengthens the prescaler period by whole ticks. The trim is applied on one second out of every programmable interval of 1 to 256 seconds, and every other second lasts the nominal period.

Software reaches the block through a small word-wide register port with four addresses: seconds, control, compensation and locks. The seconds value may be loaded only while counting is stopped. Loading it restarts the prescaler and the interval sequence. The compensation settings can be frozen by a sticky lock bit. A second sticky bit freezes the lock register itself. Only reset releases either lock.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the seconds register reads 1, the count-enable bit, the trim code, the interval field and both lock bits read 0.
- R2: With trim code 0, the seconds register advances by exactly one every BASE_PERIOD enabled ticks (32768 by default).
- R3: The trim code in compensation bits [7:0] is read as an 8-bit two's-complement value T, and a trimmed second lasts BASE_PERIOD - T ticks. For BASE_PERIOD = 32768, code 0x01 gives 32767, 0x7F gives 32641, 0xFF gives 32769 and 0x80 gives 32896.
- R4: The interval field in compensation bits [15:8] holds N. The trimmed period is used for the first second after a seconds load and then for one second in every N+1, and all other seconds last BASE_PERIOD ticks.
- R5: The prescaler advances only on cycles where tick_en is high and the count-enable bit (control bit 0) is 1. Otherwise the seconds register holds its value.
- R6: A write to address 0 while counting is disabled stores the written value, or stores 1 if the value written is 0. It also clears the prescaler and the interval sequence.
- R7: A write to address 0 while the count-enable bit is 1 has no effect.
- R8: Advancing from 0xFFFFFFFF yields 1, so the seconds register never holds 0 after reset.
- R9: Lock register bit 0 (compensation lock) is set by writing 1 and is cleared only by reset. While it is set, writes to the compensation register (address 2) are dropped.
- R10: Lock register bit 1 (lock-register lock) is set by writing 1 and is cleared only by reset. While it is set, writes to the lock register (address 3) are dropped.
- R11: Register addresses are: 0 seconds, 1 control, 2 compensation, 3 locks. reg_rdata shows the register selected by reg_addr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz tick rate |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |
| seconds_o | output | 32 | Current seconds value |

## Verification
On every cycle, the assertions check the following:
- The seconds value only ever steps by one, or wraps from all-ones to 1, unless it is loaded.
- The seconds value is frozen whenever counting is off.
- The lock bits never fall.
- The compensation fields and the lock bits stay unchanged while they are locked.

The exact length of each second under a given trim code, the placement of the trimmed second within an interval, and the zero-to-one substitution on load depend on the tick count and on the values written. Only the bench's timed scenarios and its reference model can show these.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int REG_W  = 32;
  localparam int TRIM_W = 8;
  localparam int IVAL_W = 8;

  typedef enum logic [1:0] {
    ADDR_SECONDS = 2'd0,
    ADDR_CTRL    = 2'd1,
    ADDR_COMP    = 2'd2,
    ADDR_LOCK    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rtc_comp_sequencer.sv
// Tracks the position inside the compensation interval and produces the
// prescaler period for the second currently being counted.
module rtc_comp_sequencer #(
  parameter int BASE_PERIOD = 32768,
  parameter int TRIM_W      = 8,
  parameter int IVAL_W      = 8,
  parameter int PRE_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sec_done,
  input  logic [TRIM_W-1:0] trim,
  input  logic [IVAL_W-1:0] ival_field,
  output logic [PRE_W-1:0]  period
);
  localparam logic signed [PRE_W:0] BASE_S = (PRE_W+1)'(BASE_PERIOD);

  logic [IVAL_W-1:0]      ival_cnt;
  logic                   trim_now;
  logic signed [PRE_W:0]  trim_ext;
  logic signed [PRE_W:0]  diff;

  assign trim_now = (ival_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ival_cnt <= '0;
    end else if (sec_done) begin
      if (trim_now) ival_cnt <= ival_field;
      else          ival_cnt <= ival_cnt - 1'b1;
    end
  end

  always_comb begin
    if (trim_now) trim_ext = {{(PRE_W+1-TRIM_W){trim[TRIM_W-1]}}, trim};
    else          trim_ext = '0;
    diff = BASE_S - trim_ext;
  end

  assign period = diff[PRE_W-1:0];
endmodule

// File: rtl/rtc_prescaler.sv
// Counts enabled ticks and flags the last tick of each second.
module rtc_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             count_en,
  input  logic [PRE_W-1:0] period,
  output logic             sec_done
);
  logic [PRE_W-1:0] pre_cnt;
  logic             at_end;

  // ">=" keeps the count bounded if the period shrinks mid-second
  assign at_end   = (pre_cnt >= (period - 1'b1));
  assign sec_done = count_en && at_end;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_cnt <= '0;
    end else if (count_en) begin
      if (at_end) pre_cnt <= '0;
      else        pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
// Software-visible state: seconds, count enable, compensation fields, locks.
module rtc_regfile
  import rtc_trim_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int TRIM_W = 8,
  parameter int IVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              sec_inc,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [SEC_W-1:0]  seconds,
  output logic              cnt_en,
  output logic [TRIM_W-1:0] trim,
  output logic [IVAL_W-1:0] ival_field,
  output logic              comp_lock,
  output logic              lock_lock,
  output logic              sec_load
);
  localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(1);

  logic              wr_sec, wr_ctrl, wr_comp, wr_lock;
  logic [SEC_W-1:0]  sec_plus;
  logic [SEC_W-1:0]  load_val;
  logic [REG_W-1:0]  rd_mux;

  assign wr_sec  = reg_wr && (reg_addr == ADDR_SECONDS);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_comp = reg_wr && (reg_addr == ADDR_COMP) && !comp_lock;
  assign wr_lock = reg_wr && (reg_addr == ADDR_LOCK) && !lock_lock;

  assign sec_load = wr_sec && !cnt_en;
  assign sec_plus = (seconds + SEC_ONE == '0) ? SEC_ONE : seconds + SEC_ONE;
  assign load_val = (reg_wdata[SEC_W-1:0] == '0) ? SEC_ONE : reg_wdata[SEC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      seconds <= SEC_ONE;
    end else if (sec_load) begin
      seconds <= load_val;
    end else if (sec_inc) begin
      seconds <= sec_plus;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en     <= 1'b0;
      trim       <= '0;
      ival_field <= '0;
      comp_lock  <= 1'b0;
      lock_lock  <= 1'b0;
    end else begin
      if (wr_ctrl) cnt_en <= reg_wdata[0];
      if (wr_comp) begin
        trim       <= reg_wdata[TRIM_W-1:0];
        ival_field <= reg_wdata[TRIM_W +: IVAL_W];
      end
      if (wr_lock) begin
        comp_lock <= comp_lock | reg_wdata[0];
        lock_lock <= lock_lock | reg_wdata[1];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_SECONDS: rd_mux[SEC_W-1:0] = seconds;
      ADDR_CTRL:    rd_mux[0] = cnt_en;
      ADDR_COMP:    rd_mux[TRIM_W+IVAL_W-1:0] = {ival_field, trim};
      default:      rd_mux[1:0] = {lock_lock, comp_lock};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
  import rtc_trim_pkg::*;
#(
  parameter int BASE_PERIOD = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [REG_W-1:0]  seconds_o
);
  localparam int PRE_W = $clog2(BASE_PERIOD + (1 << (TRIM_W-1)) + 1);

  logic              cnt_en;
  logic              sec_done;
  logic              sec_load;
  logic [TRIM_W-1:0] trim;
  logic [IVAL_W-1:0] ival_field;
  logic              comp_lock;
  logic              lock_lock;
  logic [PRE_W-1:0]  period;

  rtc_regfile #(.SEC_W(REG_W), .TRIM_W(TRIM_W), .IVAL_W(IVAL_W)) regs_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .sec_inc(sec_done), .reg_rdata(reg_rdata),
    .seconds(seconds_o), .cnt_en(cnt_en), .trim(trim),
    .ival_field(ival_field), .comp_lock(comp_lock), .lock_lock(lock_lock),
    .sec_load(sec_load)
  );

  rtc_comp_sequencer #(.BASE_PERIOD(BASE_PERIOD), .TRIM_W(TRIM_W),
                       .IVAL_W(IVAL_W), .PRE_W(PRE_W)) seq_i (
    .clk(clk), .rst(rst), .clear(sec_load), .sec_done(sec_done),
    .trim(trim), .ival_field(ival_field), .period(period)
  );

  rtc_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst(rst), .clear(sec_load), .count_en(cnt_en && tick_en),
    .period(period), .sec_done(sec_done)
  );
endmodule

// File: rtl/rtc_trim_checker.sv
module rtc_trim_checker #(
  parameter int SEC_W  = 32,
  parameter int TRIM_W = 8,
  parameter int IVAL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic              cnt_en,
  input logic [SEC_W-1:0]  seconds_o,
  input logic [TRIM_W-1:0] trim,
  input logic [IVAL_W-1:0] ival_field,
  input logic              comp_lock,
  input logic              lock_lock
);
  logic sec_wr;
  assign sec_wr = reg_wr && (reg_addr == 2'd0) && !cnt_en;

  assert_never_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> seconds_o != '0);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(sec_wr) && seconds_o != $past(seconds_o)) |->
    (seconds_o == $past(seconds_o) + 1'b1 ||
     ($past(seconds_o) == '1 && seconds_o == SEC_W'(1))));

  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(cnt_en) && !$past(sec_wr)) |-> $stable(seconds_o));

  assert_comp_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(comp_lock)) |->
    (comp_lock && $stable(trim) && $stable(ival_field)));

  assert_locks_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(lock_lock)) |->
    (lock_lock && $stable(comp_lock)));

  assert_locks_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> !$fell(comp_lock) && !$fell(lock_lock));
endmodule

bind rtc_seconds_core rtc_trim_checker #(
  .SEC_W(rtc_trim_pkg::REG_W), .TRIM_W(rtc_trim_pkg::TRIM_W),
  .IVAL_W(rtc_trim_pkg::IVAL_W)
) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cnt_en(cnt_en), .seconds_o(seconds_o), .trim(trim),
  .ival_field(ival_field), .comp_lock(comp_lock), .lock_lock(lock_lock)
);

// File: tb/rtc_seconds_core_tb_top.sv
module rtc_seconds_core_tb_top;
  localparam int CLK_P = 10;
  localparam int BASE  = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b1;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, seconds_o;

  int checks = 0;
  int fails  = 0;
  bit model_cmp = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rtc_seconds_core #(.BASE_PERIOD(BASE)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seconds_o(seconds_o)
  );

  // Reference model built from the requirements
  logic [31:0] m_sec, m_rd;
  logic        m_en, m_cl, m_ll;
  logic [7:0]  m_trim, m_ival, m_ic;
  int          m_pre;

  function automatic int period_of(input logic [7:0] t, input bit trimmed);
    return trimmed ? BASE - int'($signed(t)) : BASE;
  endfunction

  function automatic logic [31:0] next_sec(input logic [31:0] s);
    return (s == 32'hFFFF_FFFF) ? 32'd1 : s + 32'd1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sec <= 32'd1; m_en <= 1'b0; m_trim <= '0; m_ival <= '0;
      m_cl <= 1'b0; m_ll <= 1'b0; m_pre <= 0; m_ic <= '0; m_rd <= '0;
    end else begin
      case (reg_addr)
        2'd0: m_rd <= m_sec;
        2'd1: m_rd <= {31'd0, m_en};
        2'd2: m_rd <= {16'd0, m_ival, m_trim};
        default: m_rd <= {30'd0, m_ll, m_cl};
      endcase
      if (reg_wr && reg_addr == 2'd0 && !m_en) begin
        m_sec <= (reg_wdata == 0) ? 32'd1 : reg_wdata;
        m_pre <= 0; m_ic <= '0;
      end else if (m_en && tick_en) begin
        if (m_pre >= period_of(m_trim, m_ic == 0) - 1) begin
          m_pre <= 0;
          m_sec <= next_sec(m_sec);
          m_ic  <= (m_ic == 0) ? m_ival : m_ic - 8'd1;
        end else m_pre <= m_pre + 1;
      end
      if (reg_wr && reg_addr == 2'd1) m_en <= reg_wdata[0];
      if (reg_wr && reg_addr == 2'd2 && !m_cl) begin
        m_trim <= reg_wdata[7:0]; m_ival <= reg_wdata[15:8];
      end
      if (reg_wr && reg_addr == 2'd3 && !m_ll) begin
        m_cl <= m_cl | reg_wdata[0]; m_ll <= m_ll | reg_wdata[1];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_cmp && !rst) begin
      check("R11 random model seconds", seconds_o, m_sec);
      check("R11 random model rdata", reg_rdata, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Load seconds, enable, and time n consecutive seconds against the trim rule
  task automatic run_seconds(input string req, input logic [7:0] t,
                             input logic [7:0] iv, input int n);
    logic [31:0] prev;
    wr(2'd1, 32'd0);
    wr(2'd2, {16'd0, iv, t});
    wr(2'd0, 32'd100);
    wr(2'd1, 32'd1);
    for (int k = 0; k < n; k++) begin
      int cyc = 0;
      prev = seconds_o;
      while (seconds_o == prev && cyc < 1000) begin
        @(posedge clk); cyc++; @(negedge clk);
      end
      check(req, cyc, period_of(t, (k % (int'(iv) + 1)) == 0));
      check({req, " step"}, seconds_o, prev + 32'd1);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    process::self().srandom(32'h5EC0_0D5);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); check("R1 seconds after reset", v, 32'd1);
    rd(2'd1, v); check("R1 enable after reset", v, 32'd0);
    rd(2'd2, v); check("R1 compensation after reset", v, 32'd0);
    rd(2'd3, v); check("R1 locks after reset", v, 32'd0);
    check("R1 seconds_o after reset", seconds_o, 32'd1);

    // R6 zero load becomes one, nonzero stored
    wr(2'd0, 32'd0);  rd(2'd0, v); check("R6 zero write stores 1", v, 32'd1);
    wr(2'd0, 32'd77); rd(2'd0, v); check("R6 load value", v, 32'd77);

    // R2 / R3 trimmed periods (interval field 0 applies every second)
    run_seconds("R2 no-trim period", 8'h00, 8'd0, 3);
    run_seconds("R3 trim 0x01", 8'h01, 8'd0, 2);
    run_seconds("R3 trim 0x7F", 8'h7F, 8'd0, 2);
    run_seconds("R3 trim 0xFF", 8'hFF, 8'd0, 2);
    run_seconds("R3 trim 0x80", 8'h80, 8'd0, 2);

    // R4 interval placement
    run_seconds("R4 interval 3 trim 0x10", 8'h10, 8'd2, 7);
    run_seconds("R4 interval 2 trim 0xF0", 8'hF0, 8'd1, 5);

    // R7 write while enabled ignored (still enabled from above)
    v = seconds_o;
    wr(2'd0, 32'h1234_5678);
    check("R7 write ignored while enabled", (seconds_o == 32'h1234_5678) ? 32'd1 : 32'd0, 32'd0);

    // R5 hold while disabled, and hold while tick_en low
    wr(2'd1, 32'd0);
    v = seconds_o;
    repeat (BASE * 2) @(negedge clk);
    check("R5 hold while disabled", seconds_o, v);
    wr(2'd1, 32'd1);
    tick_en = 1'b0;
    v = seconds_o;
    repeat (BASE * 2) @(negedge clk);
    check("R5 hold while tick_en low", seconds_o, v);
    tick_en = 1'b1;

    // R8 wrap from all ones to one
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'd1);
    repeat (BASE + 2) @(negedge clk);
    check("R8 wrap to 1", seconds_o, 32'd1);

    // Random phase against the model (R11 mapping and R2-R7 combined)
    do_reset();
    model_cmp = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      tick_en  = ($urandom % 4) != 0;
      reg_addr = 2'($urandom % 3);
      reg_wr   = ($urandom % 150) == 0;
      case (reg_addr)
        2'd0: reg_wdata = ($urandom % 4 == 0) ? 32'd0 : $urandom;
        2'd1: reg_wdata = ($urandom % 5 == 0) ? 32'd0 : 32'd1;
        default: reg_wdata = {16'd0, 8'($urandom % 4), 8'($urandom)};
      endcase
    end
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b1;
    @(negedge clk);
    model_cmp = 1'b0;

    // R9 compensation lock
    do_reset();
    wr(2'd2, 32'h0000_0305);
    wr(2'd3, 32'd1);
    wr(2'd2, 32'h0000_0A0B);
    rd(2'd2, v); check("R9 locked compensation unchanged", v, 32'h0000_0305);
    wr(2'd3, 32'd0);
    rd(2'd3, v); check("R9 lock bit sticky", v, 32'd1);

    // R10 lock-register lock
    do_reset();
    rd(2'd3, v); check("R10 reset releases locks", v, 32'd0);
    wr(2'd3, 32'd2);
    wr(2'd3, 32'd1);
    rd(2'd3, v); check("R10 lock register frozen", v, 32'd2);
    wr(2'd2, 32'h0000_0107);
    rd(2'd2, v); check("R10 compensation still writable", v, 32'h0000_0107);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule